// File: doc/BRIEF.md
# Bundle Template Issue Dispersal Unit

This block sits between instruction fetch and the functional units of a statically scheduled core. Fetch hands it fixed 128-bit bundles. Each bundle carries three 41-bit operations and a 5-bit template. The template tells the block two things: which unit class each slot targets, and where the parallel groups end. The block keeps a two-bundle window. From the window it sends one group per cycle onto dedicated memory, integer, floating point and branch issue ports. Inside a group it checks nothing: software has already guaranteed that the operations of a group are independent.

A group starts at the oldest unissued slot of the head bundle. It runs to the first stop. If there is no stop, it runs to the end of the bundle behind the head. A group either goes out in full or waits in full; it never goes out in part. A bundle whose template uses the reserved pattern is thrown away and flagged. A bundle with slots still waiting stays at the head, and the window asks for a new bundle as soon as a place in it is free.

Top module: `bundle_disperse`

## Requirements
- R1: Bundle layout: the template is in bits [4:0], slot 0 in [45:5], slot 1 in [86:46] and slot 2 in [127:87]. Template bits [4:2] choose the slot classes (slot0, slot1, slot2): 0 = M I I, 1 = M M I, 2 = M F I, 3 = M I B, 4 = M B B, 5 = B B B, 6 = M M F.
- R2: Template bit 1 puts a stop after slot 1, and template bit 0 puts a stop after slot 2. A group ends at the first stop that follows its starting slot.
- R3: If there is no stop before the end of the head bundle, the group continues into the second bundle of the window. It ends there at a stop or at the last slot, and it waits until that second bundle is present.
- R4: Each operation of an issued group goes to a port of its class. Within a class, ports are filled from index 0 upward in slot order. The head bundle comes first. Per-port valids are high for exactly one cycle, and the cycle is the one after the group formed in the window.
- R5: A group that needs more than 2 M, 2 I, 2 F or 3 B ports is held whole, and nothing of it is issued.
- R6: A bundle with template bits [4:2] = 7 is accepted and discarded. `bad_tpl` is high for the one cycle after it is accepted, and none of its slots are issued.
- R7: `bnd_ready` is low exactly when the window holds two bundles. A bundle with slots not yet issued stays at the head, and its remaining slots issue later.
- R8: After reset all issue valids and `bad_tpl` are low and `bnd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bnd_valid | input | 1 | Bundle offered |
| bnd_data | input | 128 | Bundle contents |
| bnd_ready | output | 1 | Window can take a bundle |
| bad_tpl | output | 1 | Reserved template was discarded |
| m_vld | output | 2 | Memory port valids |
| m_op | output | 82 | Memory port operations, 41 bits per port |
| i_vld | output | 2 | Integer port valids |
| i_op | output | 82 | Integer port operations |
| f_vld | output | 2 | Floating point port valids |
| f_op | output | 82 | Floating point port operations |
| b_vld | output | 3 | Branch port valids |
| b_op | output | 123 | Branch port operations |

## Verification
A wrong slot pointer or window shift appears at the issue ports in the very next group. The group either repeats an operation tag, skips one, or splits at a place the templates do not give. The scoreboard sees this within one cycle. A wrong full or stall state shows up as `bnd_ready` held low with no valid on any port, or as operations issued out of a held group. Both can be seen within a few cycles of the bundle that causes them.

// File: rtl/bundle_disperse.sv
module bundle_disperse #(
  parameter int SLOT_W = 41,
  parameter int TPL_W  = 5,
  parameter int NM = 2,
  parameter int NI = 2,
  parameter int NF = 2,
  parameter int NB = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bnd_valid,
  input  logic [TPL_W+3*SLOT_W-1:0] bnd_data,
  output logic                 bnd_ready,
  output logic                 bad_tpl,
  output logic [NM-1:0]        m_vld,
  output logic [NM*SLOT_W-1:0] m_op,
  output logic [NI-1:0]        i_vld,
  output logic [NI*SLOT_W-1:0] i_op,
  output logic [NF-1:0]        f_vld,
  output logic [NF*SLOT_W-1:0] f_op,
  output logic [NB-1:0]        b_vld,
  output logic [NB*SLOT_W-1:0] b_op
);
  localparam int BW = TPL_W + 3*SLOT_W;
  localparam int NPOS = 6;
  localparam logic [1:0] C_M = 2'd0, C_I = 2'd1, C_F = 2'd2, C_B = 2'd3;

  function automatic logic [1:0] slot_cls(input logic [2:0] pat, input int s);
    logic [5:0] row;
    case (pat)
      3'd0: row = {C_M, C_I, C_I};
      3'd1: row = {C_M, C_M, C_I};
      3'd2: row = {C_M, C_F, C_I};
      3'd3: row = {C_M, C_I, C_B};
      3'd4: row = {C_M, C_B, C_B};
      3'd5: row = {C_B, C_B, C_B};
      default: row = {C_M, C_M, C_F};
    endcase
    return row[(2-s)*2 +: 2];
  endfunction

  logic [BW-1:0] w0, w1, nw0, nw1;
  logic          v0, v1, nv0, nv1;
  logic [1:0]    ptr, nptr;

  logic [1:0]        cls [NPOS];
  logic [SLOT_W-1:0] op  [NPOS];
  logic              stp [NPOS];

  always_comb begin
    for (int p = 0; p < NPOS; p++) begin
      logic [BW-1:0] b;
      int s;
      b = (p < 3) ? w0 : w1;
      s = p % 3;
      cls[p] = slot_cls(b[4:2], s);
      op[p]  = b[TPL_W + s*SLOT_W +: SLOT_W];
      stp[p] = (s == 1 && b[1]) || (s == 2 && b[0]);
    end
  end

  int   e_pos;
  logic found, complete, fits, fire;
  logic [NM-1:0] nm_vld;  logic [NM*SLOT_W-1:0] nm_op;
  logic [NI-1:0] ni_vld;  logic [NI*SLOT_W-1:0] ni_op;
  logic [NF-1:0] nf_vld;  logic [NF*SLOT_W-1:0] nf_op;
  logic [NB-1:0] nb_vld;  logic [NB*SLOT_W-1:0] nb_op;

  always_comb begin
    int cm, ci, cf, cb;
    e_pos = NPOS - 1;
    found = 1'b0;
    for (int p = 0; p < NPOS - 1; p++) begin
      if (!found && p >= int'(ptr) && stp[p]) begin
        e_pos = p;
        found = 1'b1;
      end
    end
    cm = 0; ci = 0; cf = 0; cb = 0;
    nm_vld = '0; nm_op = '0; ni_vld = '0; ni_op = '0;
    nf_vld = '0; nf_op = '0; nb_vld = '0; nb_op = '0;
    for (int p = 0; p < NPOS; p++) begin
      if (p >= int'(ptr) && p <= e_pos) begin
        case (cls[p])
          C_M: begin
            if (cm < NM) begin nm_vld[cm] = 1'b1; nm_op[cm*SLOT_W +: SLOT_W] = op[p]; end
            cm++;
          end
          C_I: begin
            if (ci < NI) begin ni_vld[ci] = 1'b1; ni_op[ci*SLOT_W +: SLOT_W] = op[p]; end
            ci++;
          end
          C_F: begin
            if (cf < NF) begin nf_vld[cf] = 1'b1; nf_op[cf*SLOT_W +: SLOT_W] = op[p]; end
            cf++;
          end
          default: begin
            if (cb < NB) begin nb_vld[cb] = 1'b1; nb_op[cb*SLOT_W +: SLOT_W] = op[p]; end
            cb++;
          end
        endcase
      end
    end
    fits = (cm <= NM) && (ci <= NI) && (cf <= NF) && (cb <= NB);
  end

  assign complete  = v0 && (e_pos < 3 || v1);
  assign fire      = complete && fits;
  assign bnd_ready = !(v0 && v1);

  logic accept, legal;
  assign accept = bnd_valid && bnd_ready;
  assign legal  = bnd_data[4:2] != 3'b111;

  always_comb begin
    nw0 = w0; nw1 = w1; nv0 = v0; nv1 = v1; nptr = ptr;
    if (fire) begin
      if (e_pos < 2) begin
        nptr = 2'(e_pos + 1);
      end else if (e_pos == NPOS - 1) begin
        nv0 = 1'b0; nv1 = 1'b0; nptr = 2'd0;
      end else begin
        nw0 = w1; nv0 = v1; nv1 = 1'b0;
        nptr = (e_pos == 2) ? 2'd0 : 2'(e_pos - 2);
      end
    end
    if (accept && legal) begin
      if (!nv0) begin nw0 = bnd_data; nv0 = 1'b1; end
      else      begin nw1 = bnd_data; nv1 = 1'b1; end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w0 <= '0; w1 <= '0; v0 <= 1'b0; v1 <= 1'b0; ptr <= '0;
      bad_tpl <= 1'b0;
      m_vld <= '0; i_vld <= '0; f_vld <= '0; b_vld <= '0;
      m_op <= '0; i_op <= '0; f_op <= '0; b_op <= '0;
    end else begin
      w0 <= nw0; w1 <= nw1; v0 <= nv0; v1 <= nv1; ptr <= nptr;
      bad_tpl <= accept && !legal;
      m_vld <= fire ? nm_vld : '0;
      i_vld <= fire ? ni_vld : '0;
      f_vld <= fire ? nf_vld : '0;
      b_vld <= fire ? nb_vld : '0;
      if (fire) begin
        m_op <= nm_op; i_op <= ni_op; f_op <= nf_op; b_op <= nb_op;
      end
    end
  end
endmodule

// File: rtl/bundle_disperse_chk.sv
module bundle_disperse_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bnd_valid,
  input logic       bnd_ready,
  input logic       bad_tpl,
  input logic [1:0] m_vld,
  input logic [1:0] i_vld,
  input logic [1:0] f_vld,
  input logic [2:0] b_vld
);
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ({m_vld, i_vld, f_vld, b_vld} == '0 && !bad_tpl && bnd_ready)); // R8
  AST_M_FILL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    m_vld[1] |-> m_vld[0]); // R4
  AST_I_FILL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    i_vld[1] |-> i_vld[0]); // R4
  AST_F_FILL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    f_vld[1] |-> f_vld[0]); // R4
  AST_B_FILL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (b_vld[2] |-> b_vld[1]) and (b_vld[1] |-> b_vld[0])); // R4
  AST_BAD_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    bad_tpl |-> $past(bnd_valid && bnd_ready)); // R6
  AST_GROUP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({m_vld, i_vld, f_vld, b_vld}) <= 6); // R3
endmodule

bind bundle_disperse bundle_disperse_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bnd_valid(bnd_valid), .bnd_ready(bnd_ready),
  .bad_tpl(bad_tpl), .m_vld(m_vld), .i_vld(i_vld), .f_vld(f_vld), .b_vld(b_vld)
);

// File: tb/bundle_disperse_tb.sv
`timescale 1ns/1ps
module bundle_disperse_tb;
  localparam int W = 41;

  logic clk = 1'b0, rst_n = 1'b0, bnd_valid = 1'b0;
  logic [127:0] bnd_data = '0;
  logic bnd_ready, bad_tpl;
  logic [1:0] m_vld, i_vld, f_vld;
  logic [2:0] b_vld;
  logic [2*W-1:0] m_op, i_op, f_op;
  logic [3*W-1:0] b_op;

  always #4 clk = ~clk;

  bundle_disperse u_dut (
    .clk(clk), .rst_n(rst_n), .bnd_valid(bnd_valid), .bnd_data(bnd_data),
    .bnd_ready(bnd_ready), .bad_tpl(bad_tpl),
    .m_vld(m_vld), .m_op(m_op), .i_vld(i_vld), .i_op(i_op),
    .f_vld(f_vld), .f_op(f_op), .b_vld(b_vld), .b_op(b_op)
  );

  typedef struct {
    logic [1:0] mv; logic [2*W-1:0] mo;
    logic [1:0] iv; logic [2*W-1:0] io;
    logic [1:0] fv; logic [2*W-1:0] fo;
    logic [2:0] bv; logic [3*W-1:0] bo;
    string tag;
  } grp_t;

  grp_t exp_q[$];
  logic [127:0] seq_q[$];
  int n_tests = 0, n_fail = 0, uid = 0;

  task automatic check(input bit ok, input string what, input string act, input string expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%s expected=%s", what, act, expv);
    end
  endtask

  // R1 class table: 0=M 1=I 2=F 3=B
  function automatic int cls_of(input logic [2:0] pat, input int s);
    case (pat)
      3'd0: return (s == 0) ? 0 : 1;
      3'd1: return (s == 2) ? 1 : 0;
      3'd2: return (s == 0) ? 0 : (s == 1) ? 2 : 1;
      3'd3: return (s == 0) ? 0 : (s == 1) ? 1 : 3;
      3'd4: return (s == 0) ? 0 : 3;
      3'd5: return 3;
      default: return (s == 2) ? 2 : 0;
    endcase
  endfunction

  function automatic logic [127:0] mk(input logic [2:0] pat, input bit s1, input bit s0);
    logic [127:0] b;
    b[4:0] = {pat, s1, s0};
    for (int s = 0; s < 3; s++)
      b[5 + s*W +: W] = {8'hA5, 31'(uid), 2'(s)};
    uid++;
    return b;
  endfunction

  // Build expected groups from the queued legal bundles (R2, R3, R4)
  task automatic plan(input string tag);
    logic [127:0] lg[$];
    int h, p, sh, n;
    bit done, ended;
    foreach (seq_q[k]) if (seq_q[k][4:2] != 3'b111) lg.push_back(seq_q[k]);
    n = lg.size(); h = 0; p = 0; done = 0;
    while (!done && h < n) begin
      grp_t g;
      int cnt[4];
      g.mv = '0; g.mo = '0; g.iv = '0; g.io = '0; g.fv = '0; g.fo = '0;
      g.bv = '0; g.bo = '0; g.tag = tag;
      cnt = '{0, 0, 0, 0};
      sh = h; ended = 0;
      while (!ended && !done) begin
        logic [W-1:0] o;
        int c;
        bit stop, endb;
        o = lg[h][5 + p*W +: W];
        c = cls_of(lg[h][4:2], p);
        case (c)
          0: begin g.mv[cnt[0]] = 1'b1; g.mo[cnt[0]*W +: W] = o; end
          1: begin g.iv[cnt[1]] = 1'b1; g.io[cnt[1]*W +: W] = o; end
          2: begin g.fv[cnt[2]] = 1'b1; g.fo[cnt[2]*W +: W] = o; end
          default: begin g.bv[cnt[3]] = 1'b1; g.bo[cnt[3]*W +: W] = o; end
        endcase
        cnt[c]++;
        stop = (p == 1 && lg[h][1]) || (p == 2 && lg[h][0]);
        endb = (p == 2 && h == sh + 1);
        p++;
        if (p == 3) begin p = 0; h++; end
        if (stop || endb) ended = 1;
        else if (h >= n) done = 1;
      end
      if (ended) exp_q.push_back(g);
    end
  endtask

  task automatic send(input logic [127:0] b);
    bnd_valid = 1'b1; bnd_data = b;
    while (!bnd_ready) @(negedge clk);
    @(negedge clk);
    bnd_valid = 1'b0;
    if (b[4:2] == 3'b111)
      check(bad_tpl === 1'b1, "R6 bad_tpl after reserved template", $sformatf("%b", bad_tpl), "1");
  endtask

  task automatic run(input string tag);
    plan(tag);
    foreach (seq_q[k]) send(seq_q[k]);
    seq_q.delete();
    repeat (8) @(negedge clk);
    check(exp_q.size() == 0, {tag, " all groups issued"}, $sformatf("%0d left", exp_q.size()), "0 left");
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bnd_valid = 1'b0;
    repeat (3) @(negedge clk);
    exp_q.delete();
    rst_n = 1'b1;
  endtask

  // Monitor: pop and compare every issued group
  always @(negedge clk) begin
    if (rst_n && ({m_vld, i_vld, f_vld, b_vld} != '0)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected issue", $sformatf("m%b i%b f%b b%b", m_vld, i_vld, f_vld, b_vld), "no issue");
      end else begin
        grp_t g;
        g = exp_q.pop_front();
        check(m_vld == g.mv && i_vld == g.iv && f_vld == g.fv && b_vld == g.bv,
              {g.tag, " R4 port valids"},
              $sformatf("m%b i%b f%b b%b", m_vld, i_vld, f_vld, b_vld),
              $sformatf("m%b i%b f%b b%b", g.mv, g.iv, g.fv, g.bv));
        check(((m_op ^ g.mo) & {{W{g.mv[1]}}, {W{g.mv[0]}}}) == '0 &&
              ((i_op ^ g.io) & {{W{g.iv[1]}}, {W{g.iv[0]}}}) == '0 &&
              ((f_op ^ g.fo) & {{W{g.fv[1]}}, {W{g.fv[0]}}}) == '0 &&
              ((b_op ^ g.bo) & {{W{g.bv[2]}}, {W{g.bv[1]}}, {W{g.bv[0]}}}) == '0,
              {g.tag, " R1 operation payloads"},
              $sformatf("%h %h %h %h", m_op, i_op, f_op, b_op),
              $sformatf("%h %h %h %h", g.mo, g.io, g.fo, g.bo));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    check(bnd_ready === 1'b1 && bad_tpl === 1'b0 && {m_vld, i_vld, f_vld, b_vld} == '0,
          "R8 reset state", $sformatf("rdy%b bad%b", bnd_ready, bad_tpl), "rdy1 bad0 idle");

    seq_q.push_back(mk(3'd0, 1'b0, 1'b1));                          // R1 single group
    run("R1 MII");
    seq_q.push_back(mk(3'd2, 1'b1, 1'b1));                          // R2 mid stop
    seq_q.push_back(mk(3'd5, 1'b0, 1'b1));                          // R4 BBB order
    run("R2 split");
    seq_q.push_back(mk(3'd3, 1'b0, 1'b0));                          // R3 cross into second
    seq_q.push_back(mk(3'd2, 1'b0, 1'b0));
    seq_q.push_back(mk(3'd5, 1'b0, 1'b1));
    run("R3 cross");
    seq_q.push_back(mk(3'd1, 1'b1, 1'b0));                          // R7 head stays
    seq_q.push_back(mk(3'd3, 1'b0, 1'b1));
    seq_q.push_back(mk(3'd6, 1'b1, 1'b0));
    seq_q.push_back(mk(3'd4, 1'b0, 1'b1));
    run("R7 partial head");
    seq_q.push_back(mk(3'd7, 1'b0, 1'b1));                          // R6 reserved
    seq_q.push_back(mk(3'd0, 1'b1, 1'b1));
    run("R6 reserved");
    @(negedge clk);
    check(bad_tpl === 1'b0, "R6 flag lasts one cycle", $sformatf("%b", bad_tpl), "0");

    for (int k = 0; k < 24; k++)
      seq_q.push_back(mk(3'($urandom % 7), 1'($urandom % 2), 1'b1));
    run("R4 stream");

    // R5 / R7: four M ops in one group stall whole, window full
    send(mk(3'd1, 1'b0, 1'b0));
    send(mk(3'd6, 1'b0, 1'b1));
    for (int k = 0; k < 4; k++) begin
      repeat (5) @(negedge clk);
      check(bnd_ready === 1'b0, "R7 ready low with full window", $sformatf("%b", bnd_ready), "0");
      check({m_vld, i_vld, f_vld, b_vld} == '0, "R5 oversubscribed group held",
            $sformatf("%b", {m_vld, i_vld, f_vld, b_vld}), "0");
    end
    do_reset();
    @(negedge clk);
    check(bnd_ready === 1'b1, "R8 ready after reset", $sformatf("%b", bnd_ready), "1");
    seq_q.push_back(mk(3'd4, 1'b1, 1'b1));
    run("R2 after reset");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule